// File: doc/BRIEF.md
# Conflict-Clearing Translation Buffer

A small fully associative address translation buffer. Software installs an entry by naming a slot and supplying the virtual page number, the address-space identifier, a global flag, the physical frame number and a valid flag. A lookup port compares the requested page and address space against every slot in parallel. It returns hit, the slot index and the frame number without a clock edge in between.

Software does not have to probe before it writes. When a new valid entry is installed, any other valid slot that the new entry overlaps is dropped on the same clock edge. The install itself always completes. A registered conflict flag records whether the most recent write removed anything. The flag keeps its value until the next write and then takes that write's result, so a write with no overlap clears it. Because of this rule, the buffer never holds two entries that a single lookup could both hit.

Top module: `xlate_buf`

## Requirements
- R1: After reset every slot is invalid, every lookup misses and `conflict_o` is 0.
- R2: A write with `wr_en_i`=1 stores the VPN, ASID, global bit, PFN and valid bit in slot `wr_idx_i` on the next rising clock edge. A lookup after that edge which matches the entry returns hit=1, that index and that PFN.
- R3: A slot matches a lookup when it is valid, its VPN equals `lk_vpn_i`, and it is global or its ASID equals `lk_asid_i`. The result is combinational. On a miss, `lk_idx_o` and `lk_pfn_o` are 0.
- R4: Two entries overlap when both are valid, their VPNs are equal, and at least one is global or their ASIDs are equal. On a valid write, every other valid slot that overlaps the new entry becomes invalid on the same edge that installs the new entry.
- R5: A write that removes at least one other slot sets `conflict_o` to 1 after its edge, and the new entry is still installed.
- R6: Cycles without a write, including any lookups, leave `conflict_o` unchanged.
- R7: A write that overlaps no other slot clears `conflict_o` after its edge.
- R8: At no time do two slots match the same lookup.
- R9: A write with `wr_vld_i`=0 makes the addressed slot invalid, never counts as a conflict, and therefore clears `conflict_o`.
- R10: The slot being overwritten is left out of the overlap check, so rewriting a slot with the same page is not a conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | 4 | Slot to write |
| wr_vpn_i | input | 20 | Virtual page number to install |
| wr_asid_i | input | 8 | Address-space identifier to install |
| wr_glb_i | input | 1 | Entry ignores the ASID |
| wr_pfn_i | input | 20 | Physical frame number to install |
| wr_vld_i | input | 1 | Valid flag to install |
| lk_vpn_i | input | 20 | Lookup virtual page number |
| lk_asid_i | input | 8 | Lookup address-space identifier |
| lk_hit_o | output | 1 | Lookup matched a slot |
| lk_idx_o | output | 4 | Matching slot, 0 on a miss |
| lk_pfn_o | output | 20 | Matching frame number, 0 on a miss |
| conflict_o | output | 1 | Result of the most recent write: it removed other slots |

## Verification
The lookup outputs follow the lookup inputs in the same cycle. The stored entries and `conflict_o` change only on the rising edge that samples `wr_en_i`, so a write's effects can be seen from the following cycle on. The driver changes inputs on the falling edge and queues the expected hit, index, PFN and flag. The monitor compares them a quarter period later, before the next rising edge. Every lookup is therefore checked against the state left by the writes that completed before it.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int unsigned VPN_W  = 20;
  localparam int unsigned ASID_W = 8;
  localparam int unsigned PFN_W  = 20;

  typedef struct packed {
    logic              glb;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
  } xtag_t;
endpackage

// File: rtl/xlate_slot.sv
module xlate_slot
  import xlate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              kill_i,
  input  logic              vld_i,
  input  xtag_t             tag_i,
  input  logic [PFN_W-1:0]  pfn_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              lk_hit_o,
  output logic              ovl_o,
  output logic [PFN_W-1:0]  pfn_o
);
  logic             vld_q;
  xtag_t            tag_q;
  logic [PFN_W-1:0] pfn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      tag_q <= '0;
      pfn_q <= '0;
    end else if (load_i) begin
      vld_q <= vld_i;
      tag_q <= tag_i;
      pfn_q <= pfn_i;
    end else if (kill_i) begin
      vld_q <= 1'b0;
    end
  end

  assign lk_hit_o = vld_q && (tag_q.vpn == lk_vpn_i)
                    && (tag_q.glb || (tag_q.asid == lk_asid_i));
  // overlap against the incoming write tag
  assign ovl_o    = vld_q && (tag_q.vpn == tag_i.vpn)
                    && (tag_q.glb || tag_i.glb || (tag_q.asid == tag_i.asid));
  assign pfn_o    = pfn_q;

  p_kill_drops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_i && !load_i) |=> !vld_q);
  p_load_takes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (vld_q == $past(vld_i)) && (pfn_q == $past(pfn_i)));
endmodule

// File: rtl/xlate_enc.sv
module xlate_enc #(
  parameter int unsigned N_ENT = 16,
  parameter int unsigned PFN_W = 20,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0]            hit_vec_i,
  input  logic [N_ENT-1:0][PFN_W-1:0] pfn_arr_i,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            idx_o,
  output logic [PFN_W-1:0]            pfn_o
);
  // at most one hit is guaranteed upstream, so an OR tree suffices
  always_comb begin
    idx_o = '0;
    pfn_o = '0;
    for (int i = 0; i < int'(N_ENT); i++) begin
      if (hit_vec_i[i]) begin
        idx_o = idx_o | IDX_W'(i);
        pfn_o = pfn_o | pfn_arr_i[i];
      end
    end
  end
  assign hit_o = |hit_vec_i;
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
  import xlate_pkg::*;
#(
  parameter int unsigned N_ENT = 16,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_glb_i,
  input  logic [PFN_W-1:0]  wr_pfn_i,
  input  logic              wr_vld_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              lk_hit_o,
  output logic [IDX_W-1:0]  lk_idx_o,
  output logic [PFN_W-1:0]  lk_pfn_o,
  output logic              conflict_o
);
  xtag_t                       wr_tag;
  logic [N_ENT-1:0]            hit_vec, ovl_vec, conf_vec, load_vec;
  logic [N_ENT-1:0][PFN_W-1:0] pfn_arr;
  logic                        conflict_q;

  assign wr_tag = '{glb: wr_glb_i, asid: wr_asid_i, vpn: wr_vpn_i};

  for (genvar g = 0; g < int'(N_ENT); g++) begin : g_slot
    assign load_vec[g] = wr_en_i && (wr_idx_i == IDX_W'(g));
    // slot being overwritten is excluded; an invalid write never conflicts
    assign conf_vec[g] = wr_en_i && wr_vld_i && ovl_vec[g] && !load_vec[g];

    xlate_slot i_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load_vec[g]),
      .kill_i    (conf_vec[g]),
      .vld_i     (wr_vld_i),
      .tag_i     (wr_tag),
      .pfn_i     (wr_pfn_i),
      .lk_vpn_i  (lk_vpn_i),
      .lk_asid_i (lk_asid_i),
      .lk_hit_o  (hit_vec[g]),
      .ovl_o     (ovl_vec[g]),
      .pfn_o     (pfn_arr[g])
    );
  end

  xlate_enc #(.N_ENT(N_ENT), .PFN_W(PFN_W)) i_enc (
    .hit_vec_i (hit_vec),
    .pfn_arr_i (pfn_arr),
    .hit_o     (lk_hit_o),
    .idx_o     (lk_idx_o),
    .pfn_o     (lk_pfn_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      conflict_q <= 1'b0;
    else if (wr_en_i) conflict_q <= |conf_vec;
  end
  assign conflict_o = conflict_q;

  p_single_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  p_miss_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_idx_o == '0) && (lk_pfn_o == '0));
  p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (|conf_vec)) |=> conflict_o);
  p_flag_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !(|conf_vec)) |=> !conflict_o);
  p_flag_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(conflict_o));
  p_new_entry_hits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_vld_i) |=> $countones(hit_vec) <= 1);
endmodule

// File: tb/test_xlate_buf.sv
module test_xlate_buf;
  localparam int CLK_P = 10;
  localparam int N     = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_glb = 1'b0, wr_vld = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [19:0] wr_vpn = '0, wr_pfn = '0, lk_vpn = '0;
  logic [7:0]  wr_asid = '0, lk_asid = '0;
  logic        lk_hit, conflict;
  logic [3:0]  lk_idx;
  logic [19:0] lk_pfn;

  always #(CLK_P/2) clk = ~clk;

  xlate_buf i_xlate_buf (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_vpn_i(wr_vpn), .wr_asid_i(wr_asid), .wr_glb_i(wr_glb),
    .wr_pfn_i(wr_pfn), .wr_vld_i(wr_vld), .lk_vpn_i(lk_vpn),
    .lk_asid_i(lk_asid), .lk_hit_o(lk_hit), .lk_idx_o(lk_idx),
    .lk_pfn_o(lk_pfn), .conflict_o(conflict)
  );

  typedef struct {
    logic hit; logic [3:0] idx; logic [19:0] pfn; logic flag; string req;
  } exp_t;
  exp_t sb[$];

  int total = 0, bad = 0;
  bit done = 0;

  // reference model
  logic        m_vld[N], m_glb[N], m_flag;
  logic [19:0] m_vpn[N], m_pfn[N];
  logic [7:0]  m_asid[N];

  task automatic wr(input int idx, input logic [19:0] vpn, input logic [7:0] asid,
                    input logic glb, input logic [19:0] pfn, input logic vld);
    logic any;
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(idx); wr_vpn = vpn; wr_asid = asid;
    wr_glb = glb; wr_pfn = pfn; wr_vld = vld;
    any = 0;
    for (int j = 0; j < N; j++)
      if (vld && j != idx && m_vld[j] && m_vpn[j] == vpn &&
          (m_glb[j] || glb || m_asid[j] == asid)) begin
        m_vld[j] = 0; any = 1;
      end
    m_vld[idx] = vld; m_vpn[idx] = vpn; m_asid[idx] = asid;
    m_glb[idx] = glb; m_pfn[idx] = pfn; m_flag = any;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input logic [19:0] vpn, input logic [7:0] asid, input string req);
    exp_t e;
    @(negedge clk);
    lk_vpn = vpn; lk_asid = asid;
    e.hit = 0; e.idx = '0; e.pfn = '0; e.flag = m_flag; e.req = req;
    for (int j = 0; j < N; j++)
      if (m_vld[j] && m_vpn[j] == vpn && (m_glb[j] || m_asid[j] == asid)) begin
        e.hit = 1; e.idx = 4'(j); e.pfn = m_pfn[j];
      end
    sb.push_back(e);
  endtask

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    #(CLK_P/4);
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (lk_hit !== e.hit || lk_idx !== e.idx || lk_pfn !== e.pfn || conflict !== e.flag) begin
        bad++;
        $display("FAIL %s: got hit=%0b idx=%0d pfn=%h flag=%0b exp hit=%0b idx=%0d pfn=%h flag=%0b",
                 e.req, lk_hit, lk_idx, lk_pfn, conflict, e.hit, e.idx, e.pfn, e.flag);
      end
    end
  end

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int j = 0; j < N; j++) begin
      m_vld[j] = 0; m_glb[j] = 0; m_vpn[j] = '0; m_asid[j] = '0; m_pfn[j] = '0;
    end
    m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    look(20'h0, 8'h0, "R1");
    look(20'h00123, 8'h05, "R1");

    wr(3, 20'h00A00, 8'h05, 0, 20'h11111, 1);
    look(20'h00A00, 8'h05, "R2");
    look(20'h00A00, 8'h06, "R3");
    wr(4, 20'h00A00, 8'h06, 0, 20'h22222, 1);
    look(20'h00A00, 8'h06, "R3");
    look(20'h00A00, 8'h05, "R3");

    wr(7, 20'h00A00, 8'h00, 1, 20'h77777, 1);  // global kills slots 3 and 4
    look(20'h00A00, 8'h05, "R4");
    look(20'h00A00, 8'h06, "R5");
    repeat (4) @(negedge clk);
    look(20'h00A00, 8'h33, "R6");
    look(20'h0BEEF, 8'h33, "R6");

    wr(7, 20'h00A00, 8'h00, 1, 20'h78787, 1);  // same slot, same page
    look(20'h00A00, 8'h01, "R10");
    look(20'h00A00, 8'h01, "R7");

    wr(0, 20'h00A00, 8'h09, 0, 20'h0A0A0, 1);  // non-global vs existing global
    look(20'h00A00, 8'h09, "R4");
    look(20'h00A00, 8'h02, "R4");

    wr(2, 20'h00B00, 8'h01, 0, 20'h0B001, 1);
    wr(9, 20'h00B00, 8'h01, 0, 20'h0B009, 1);
    look(20'h00B00, 8'h01, "R5");
    wr(10, 20'h00C00, 8'h01, 0, 20'h0C000, 0);
    look(20'h00C00, 8'h01, "R9");
    wr(9, 20'h00B00, 8'h01, 0, 20'h0B009, 0);
    look(20'h00B00, 8'h01, "R9");
    wr(11, 20'h00D00, 8'h01, 0, 20'h0D000, 1);
    look(20'h00D00, 8'h01, "R7");

    lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      wr(int'(lf[3:0]), 20'(lf[5:4]), 8'(lf[7:6] % 3), lf[9:8] == 2'b00,
         {4'h0, lf}, lf[11:10] != 2'b00);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      look(20'(lf[1:0]), 8'(lf[3:2] % 3), "R8");
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule